// File: doc/BRIEF.md
# Branch Condition Evaluator

This block looks at one 16-bit instruction word per clock and settles the questions a small core asks about short relative branches and condition-code words. For a branch it reports whether the word belongs to the branch class, whether the condition holds for the current flags, and the next fetch address. For the flag-manipulation words and the priority-setting words it produces an updated status word and a write strobe. Every output is registered, so results appear one clock after the inputs are presented.

The status input carries the flags in its low nibble and a 3-bit priority level in bits 7:5. The program-counter input is the address that already points past the branch word. Words that the block does not claim leave its outputs in a neutral state, so a neighbouring decoder can take them.

Top module: `branch_cond_eval`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: All outputs follow the inputs of the previous rising edge. `br_valid` is 1 exactly when `insn[15:8]` is 0x01 to 0x07 or 0x80 to 0x87. For any other high byte, `br_valid` and `br_taken` are 0.
- R3: The status flags are N = bit 3, Z = bit 2, V = bit 1, C = bit 0. For high bytes 0x01 to 0x07, the branch is taken when, in order: always; Z==0; Z==1; (N^V)==0; (N^V)==1; ((N^V)|Z)==0; ((N^V)|Z)==1.
- R4: For high bytes 0x80 to 0x87, the branch is taken when, in order: N==0; N==1; C==0 and Z==0; C|Z; V==0; V==1; C==0; C==1.
- R5: `br_target` is `next_pc` plus two times the sign-extended `insn[7:0]`, wrapping modulo 2^ADDR_W, when the branch is taken. In all other cases it equals `next_pc`.
- R6: `nop_hit` is 1 exactly for the words 0o000240 (0x00A0) and 0o000260 (0x00B0). Those words leave `stat_next` equal to `status`.
- R7: A word matching 0o000240 to 0o000277 (`insn[15:5]` == 0b101) with bit 4 = 1 sets to 1 each flag whose bit is 1 in `insn[3:0]`. All other status bits keep their values.
- R8: A word of that group with bit 4 = 0 clears each flag whose bit is 1 in `insn[3:0]`. All other status bits keep their values.
- R9: A word 0o000230 to 0o000237 (`insn[15:3]` == 0b10011) writes `insn[2:0]` into status bits 7:5. All other status bits keep their values.
- R10: `stat_we` is 1 exactly for the words covered by R7, R8 and R9. For every other word, `stat_next` equals `status`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 16 | Instruction word under evaluation |
| status | input | STAT_W | Current status: flags in bits 3:0, priority in 7:5 |
| next_pc | input | ADDR_W | Program counter already past the branch word |
| br_valid | output | 1 | Word is a recognised short branch |
| br_taken | output | 1 | Branch condition holds |
| br_target | output | ADDR_W | Next fetch address |
| nop_hit | output | 1 | Word is one of the two no-operation encodings |
| stat_we | output | 1 | Status update strobe |
| stat_next | output | STAT_W | Updated status value |

## Verification
The bench walks every one of the fifteen branch codes through all sixteen flag combinations. This catches a design that swaps two conditions, inverts one, or mixes up the unsigned and signed compare groups. The offsets include +127, -128 and -1, and the program counter is placed next to the wrap point. This exposes a design that forgets sign extension, omits the doubling, or loses the carry out of the top bit. The high bytes 0x00, 0x08, 0x7F and 0x88 sit next to the valid ranges; a decoder with loose range compares would claim them. The flag words with every mask, and the priority words with every level, are applied over several status patterns. A design that wrote unselected flags, or touched bits outside 7:5, would change a bit that should be preserved.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam int INSN_W = 16;
  localparam int OFF_W  = 8;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;

  localparam int PRI_LO = 5;
  localparam int PRI_HI = 7;

  // group prefixes of the non-branch words handled here
  localparam logic [10:0] CC_PREFIX  = 11'b000_0000_0101;
  localparam logic [12:0] PRI_PREFIX = 13'b0_0000_0001_0011;
  localparam logic [15:0] NOP_A      = 16'h00A0;
  localparam logic [15:0] NOP_B      = 16'h00B0;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/bce_cond.sv
module bce_cond
  import bce_pkg::*;
(
  input  logic [7:0] opc,
  input  flags_t     fl,
  output logic       is_branch,
  output logic       cond_true
);

  logic nxv;
  assign nxv = fl.n ^ fl.v;

  always_comb begin
    is_branch = 1'b1;
    cond_true = 1'b0;
    unique case (opc)
      8'h01: cond_true = 1'b1;
      8'h02: cond_true = ~fl.z;
      8'h03: cond_true = fl.z;
      8'h04: cond_true = ~nxv;
      8'h05: cond_true = nxv;
      8'h06: cond_true = ~(nxv | fl.z);
      8'h07: cond_true = nxv | fl.z;
      8'h80: cond_true = ~fl.n;
      8'h81: cond_true = fl.n;
      8'h82: cond_true = ~(fl.c | fl.z);
      8'h83: cond_true = fl.c | fl.z;
      8'h84: cond_true = ~fl.v;
      8'h85: cond_true = fl.v;
      8'h86: cond_true = ~fl.c;
      8'h87: cond_true = fl.c;
      default: is_branch = 1'b0;
    endcase
  end

endmodule

// File: rtl/bce_target.sv
module bce_target #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [OFF_W-1:0]  disp,
  input  logic              take,
  output logic [ADDR_W-1:0] dest
);

  localparam int EXT_W = ADDR_W - OFF_W - 1;

  logic [ADDR_W-1:0] disp_x2;
  assign disp_x2 = {{EXT_W{disp[OFF_W-1]}}, disp, 1'b0};
  assign dest    = take ? (pc_in + disp_x2) : pc_in;

endmodule

// File: rtl/bce_ccgrp.sv
module bce_ccgrp
  import bce_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic [INSN_W-1:0] word,
  input  logic [STAT_W-1:0] st_in,
  output logic [STAT_W-1:0] st_out,
  output logic              upd,
  output logic              is_nop
);

  logic cc_grp, pri_grp;
  logic [3:0] flag_new;

  assign cc_grp  = (word[15:5] == CC_PREFIX);
  assign pri_grp = (word[15:3] == PRI_PREFIX);
  assign is_nop  = (word == NOP_A) || (word == NOP_B);
  assign upd     = cc_grp | pri_grp;

  // one slice per condition flag: selected flags take bit 4
  for (genvar i = 0; i < 4; i++) begin : g_flag
    assign flag_new[i] = (cc_grp && word[i]) ? word[4] : st_in[i];
  end

  always_comb begin
    st_out      = st_in;
    st_out[3:0] = flag_new;
    if (pri_grp) st_out[PRI_HI:PRI_LO] = word[2:0];
  end

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       insn,
  input  logic [STAT_W-1:0] status,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              br_valid,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic              nop_hit,
  output logic              stat_we,
  output logic [STAT_W-1:0] stat_next
);

  flags_t            fl;
  logic              is_br, cond_ok, take;
  logic [ADDR_W-1:0] dest;
  logic [STAT_W-1:0] st_upd;
  logic              upd, nop_c;

  assign fl = '{n: status[FLAG_N], z: status[FLAG_Z],
                v: status[FLAG_V], c: status[FLAG_C]};

  bce_cond u_cond (
    .opc       (insn[15:8]),
    .fl        (fl),
    .is_branch (is_br),
    .cond_true (cond_ok)
  );

  assign take = is_br & cond_ok;

  bce_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .pc_in (next_pc),
    .disp  (insn[OFF_W-1:0]),
    .take  (take),
    .dest  (dest)
  );

  bce_ccgrp #(.STAT_W(STAT_W)) u_cc (
    .word   (insn),
    .st_in  (status),
    .st_out (st_upd),
    .upd    (upd),
    .is_nop (nop_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      br_valid  <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
      nop_hit   <= 1'b0;
      stat_we   <= 1'b0;
      stat_next <= '0;
    end else begin
      br_valid  <= is_br;
      br_taken  <= take;
      br_target <= dest;
      nop_hit   <= nop_c;
      stat_we   <= upd;
      stat_next <= st_upd;
    end
  end

endmodule

// File: rtl/branch_cond_eval_chk.sv
module branch_cond_eval_chk #(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       insn,
  input logic [STAT_W-1:0] status,
  input logic [ADDR_W-1:0] next_pc,
  input logic              br_valid,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic              nop_hit,
  input logic              stat_we,
  input logic [STAT_W-1:0] stat_next
);

  logic in_branch_set, in_cc, in_pri;
  assign in_branch_set = (insn[15:8] >= 8'h01 && insn[15:8] <= 8'h07) ||
                         (insn[15:8] >= 8'h80 && insn[15:8] <= 8'h87);
  assign in_cc  = (insn[15:5] == 11'h005);
  assign in_pri = (insn[15:3] == 13'h0013);

  p_taken_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> br_valid);

  p_unclaimed_r2: assert property (@(posedge clk) disable iff (rst)
    !in_branch_set |=> (!br_valid && !br_taken));

  p_fallthrough_r5: assert property (@(posedge clk) disable iff (rst)
    !in_branch_set |=> (br_target == $past(next_pc)));

  p_cc_upper_kept_r7: assert property (@(posedge clk) disable iff (rst)
    in_cc |=> (stat_we && stat_next[STAT_W-1:4] == $past(status[STAT_W-1:4])));

  p_pri_level_r9: assert property (@(posedge clk) disable iff (rst)
    in_pri |=> (stat_we && stat_next[7:5] == $past(insn[2:0])
                && stat_next[4:0] == $past(status[4:0])));

  p_other_words_r10: assert property (@(posedge clk) disable iff (rst)
    (!in_cc && !in_pri) |=> (!stat_we && stat_next == $past(status)));

  p_class_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(br_valid && (stat_we || nop_hit)));

endmodule

bind branch_cond_eval branch_cond_eval_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .insn      (insn),
  .status    (status),
  .next_pc   (next_pc),
  .br_valid  (br_valid),
  .br_taken  (br_taken),
  .br_target (br_target),
  .nop_hit   (nop_hit),
  .stat_we   (stat_we),
  .stat_next (stat_next)
);

// File: tb/branch_cond_eval_test.sv
`timescale 1ns/1ps
module branch_cond_eval_test;

  localparam int ADDR_W = 16;
  localparam int STAT_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       insn = '0;
  logic [STAT_W-1:0] status = '0;
  logic [ADDR_W-1:0] next_pc = '0;
  logic              br_valid, br_taken, nop_hit, stat_we;
  logic [ADDR_W-1:0] br_target;
  logic [STAT_W-1:0] stat_next;

  int checks = 0;
  int errors = 0;

  bit          have_exp = 0;
  string       exp_tag;
  int          e_valid, e_taken, e_target, e_nop, e_we, e_stat;

  always #10 clk = ~clk;

  branch_cond_eval #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) uut (
    .clk(clk), .rst(rst), .insn(insn), .status(status), .next_pc(next_pc),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .nop_hit(nop_hit), .stat_we(stat_we), .stat_next(stat_next)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (insn=%h)", tag, what, act, exp, insn);
    end
  endtask

  // behavioural reference from the requirements
  task automatic predict(int w, int st, int pc);
    int hb, n, z, v, c, valid, tk, off, s;
    hb = (w >> 8) & 'hFF;
    n = (st >> 3) & 1; z = (st >> 2) & 1; v = (st >> 1) & 1; c = st & 1;
    valid = 1; tk = 0;
    case (hb)
      'h01: tk = 1;
      'h02: tk = (z == 0);
      'h03: tk = (z == 1);
      'h04: tk = ((n ^ v) == 0);
      'h05: tk = ((n ^ v) == 1);
      'h06: tk = (((n ^ v) | z) == 0);
      'h07: tk = (((n ^ v) | z) == 1);
      'h80: tk = (n == 0);
      'h81: tk = (n == 1);
      'h82: tk = (c == 0 && z == 0);
      'h83: tk = (c == 1 || z == 1);
      'h84: tk = (v == 0);
      'h85: tk = (v == 1);
      'h86: tk = (c == 0);
      'h87: tk = (c == 1);
      default: valid = 0;
    endcase
    off = w & 'hFF;
    if (off >= 128) off = off - 256;
    e_valid  = valid;
    e_taken  = tk;
    e_target = tk ? ((pc + 2 * off) & 'hFFFF) : pc;
    e_nop    = (w == 'o240 || w == 'o260) ? 1 : 0;
    s = st;
    e_we = 0;
    if ((w >> 5) == 5) begin
      e_we = 1;
      for (int i = 0; i < 4; i++)
        if ((w >> i) & 1) begin
          if ((w >> 4) & 1) s = s | (1 << i);
          else              s = s & ~(1 << i);
        end
    end
    if ((w >> 3) == 'o23) begin
      e_we = 1;
      s = (s & ~('h7 << 5)) | ((w & 7) << 5);
    end
    e_stat = s;
  endtask

  task automatic compare_prev();
    if (have_exp) begin
      chk(exp_tag, "br_valid",  int'(br_valid),  e_valid);
      chk(exp_tag, "br_taken",  int'(br_taken),  e_taken);
      chk(exp_tag, "br_target", int'(br_target), e_target);
      chk(exp_tag, "nop_hit",   int'(nop_hit),   e_nop);
      chk(exp_tag, "stat_we",   int'(stat_we),   e_we);
      chk(exp_tag, "stat_next", int'(stat_next), e_stat);
    end
  endtask

  task automatic step(int w, int st, int pc, string tag);
    @(negedge clk);
    compare_prev();
    insn    = w[15:0];
    status  = st[15:0];
    next_pc = pc[15:0];
    predict(w, st, pc);
    exp_tag  = tag;
    have_exp = 1;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int pcs[4];
    int offs[5];
    int stats[3];
    pcs   = '{'h1000, 'hFFFE, 'h0004, 'h8000};
    offs  = '{'h7F, 'h80, 'hFF, 'h00, 'h23};
    stats = '{'h0000, 'hFFFF, 'hA5F0};

    // R1: reset holds outputs at zero even with a taken branch applied
    rst = 1'b1; insn = 16'h0105; status = 16'h000F; next_pc = 16'h2000;
    repeat (3) @(negedge clk);
    chk("R1", "br_valid",  int'(br_valid),  0);
    chk("R1", "br_taken",  int'(br_taken),  0);
    chk("R1", "br_target", int'(br_target), 0);
    chk("R1", "nop_hit",   int'(nop_hit),   0);
    chk("R1", "stat_we",   int'(stat_we),   0);
    chk("R1", "stat_next", int'(stat_next), 0);
    rst = 1'b0;

    // R3: signed-compare group over all flag combinations
    for (int hb = 1; hb <= 7; hb++)
      for (int f = 0; f < 16; f++)
        step((hb << 8) | offs[f % 5], 'h0F00 | f, pcs[f % 4], "R3");

    // R4: flag-test group over all flag combinations
    for (int hb = 'h80; hb <= 'h87; hb++)
      for (int f = 0; f < 16; f++)
        step((hb << 8) | offs[(f + 2) % 5], 'h00E0 | f, pcs[(f + 1) % 4], "R4");

    // R5: offset extremes and address wrap
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < 4; p++)
        step('h0100 | offs[k], 0, pcs[p], "R5");
    step('h0300 | 'h80, 'h4, 'h0000, "R5");
    step('h0300 | 'h80, 'h0, 'h0000, "R5");

    // R2: high bytes next to the valid ranges are not claimed
    step('h0000 | 'h7F, 'h000F, 'h1234, "R2");
    step('h0800 | 'h10, 'h000F, 'h1234, "R2");
    step('h7F00 | 'h10, 'h000F, 'h1234, "R2");
    step('h8800 | 'hF0, 'h000F, 'h1234, "R2");
    step('hFF00 | 'hFF, 'h0000, 'h1234, "R2");

    // R6: the two no-operation encodings
    for (int s = 0; s < 3; s++) begin
      step('o240, stats[s], 'h0100, "R6");
      step('o260, stats[s], 'h0100, "R6");
    end

    // R7 and R8: every mask with set and clear
    for (int s = 0; s < 3; s++)
      for (int m = 0; m < 16; m++) begin
        step('o260 | m, stats[s], 'h0200, "R7");
        step('o240 | m, stats[s], 'h0200, "R8");
      end

    // R9: every priority level
    for (int s = 0; s < 3; s++)
      for (int l = 0; l < 8; l++)
        step('o230 | l, stats[s], 'h0300, "R9");

    // R10: neighbouring words leave status alone
    step('o227, 'hFFFF, 'h0400, "R10");
    step('o220, 'h5A5A, 'h0400, "R10");
    step('o300, 'h5A5A, 'h0400, "R10");
    step('o1240, 'h00FF, 'h0400, "R10");
    step('o100240, 'h00FF, 'h0400, "R10");

    @(negedge clk);
    compare_prev();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule